// File: doc/BRIEF.md
# Nine-Bit Word Packer for a Byte-Wide Serial Shifter

This block feeds a three-wire display link through a serial shifter that can only move whole 8-bit bytes. On that link every byte travels as a 9-bit word: a leading flag bit (1 for data, 0 for a command) and then the byte, most significant bit first. The packer takes a stream of bytes, each tagged as data or command and marked at the end of a message. It lays the 9-bit words end to end and cuts the resulting bit string into output bytes, so that eight input bytes fill exactly nine output bytes.

A command goes out as one frame in which seven all-zero words (no-operations) come before the flagged command word. A data message that does not fill its last group of eight is padded with zero bits up to a full nine-byte frame. An optional pair swap reverses each pair of data bytes before packing, so that 16-bit pixels held low byte first go out high byte first. Long data messages are split into bursts whose size comes from the downstream buffer size, and an end marker on the output closes every burst.

Top module: `nine_bit_packer`

## Requirements
- R1: After a synchronous reset with `pk_out_rdy` high and no input, `pk_out_vld` is low and `pk_in_rdy` is high.
- R2: A complete group of eight data bytes d0..d7 yields nine output bytes that hold the words {1,d0}..{1,d7} back to back, first bit in bit 7 of the first byte. The first output byte is {1, d0[7:1]} and the ninth equals d7.
- R3: A command byte c (`pk_in_is_data` = 0) that carries the end marker yields nine output bytes: eight bytes of 0x00 and then c. The end marker is set on the byte c only.
- R4: A command beat without the end marker is illegal. That beat, and every further beat up to and including the next beat that carries the end marker, is consumed and produces no output.
- R5: A data message whose last group has m < 8 bytes ends with a nine-byte frame. That frame holds the m flagged words and then zero bits up to 72 bits.
- R6: With `pk_swap` high, each complete pair of data bytes (a, b) counted from the start of the message is packed as b then a. A lone final byte of an odd-length message is packed unchanged.
- R7: The burst size is CHUNK = max(8, floor(OUT_BUF_BYTES/9)*8) input bytes. The output end marker is set on the last byte of the frame that closes each burst, and on the last byte of the frame that closes the message. It is set on no other byte.
- R8: While `pk_out_vld` is high and `pk_out_rdy` is low, `pk_out_vld`, `pk_out_byte` and `pk_out_end` stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pk_swap | input | 1 | Reverse each data byte pair before packing |
| pk_in_vld | input | 1 | Input byte valid |
| pk_in_rdy | output | 1 | Input byte accepted when high with valid |
| pk_in_byte | input | 8 | Input byte |
| pk_in_is_data | input | 1 | 1 = data byte, 0 = command byte |
| pk_in_end | input | 1 | Last byte of the message |
| pk_out_vld | output | 1 | Output byte valid |
| pk_out_rdy | input | 1 | Downstream shifter takes the byte |
| pk_out_byte | output | 8 | Packed output byte |
| pk_out_end | output | 1 | Last byte of a burst or message frame |

## Verification
The bench builds the packer with OUT_BUF_BYTES = 18, which gives a 16-byte burst. A sweep of data message lengths from 1 to 40 therefore crosses two burst boundaries and reaches every tail length from one to seven, in both swap modes and for both odd and even lengths. Half of the sweep runs with a downstream ready that drops every third cycle, so frames are built under stall. Command frames and illegal multi-byte commands are mixed in between the data messages.

// File: rtl/nbp_pkg.sv
// Shared types of the nine-bit packer.
// Assumes: nothing beyond the 1800-2017 language.
package nbp_pkg;

    // Packer core sequencing states.
    typedef enum logic [2:0] {
        PK_RUN  = 3'd0,
        PK_PAD  = 3'd1,
        PK_NOPS = 3'd2,
        PK_CMD  = 3'd3,
        PK_DROP = 3'd4
    } pack_state_t;

    // Pair reorder stage states.
    typedef enum logic [1:0] {
        SW_PASS  = 2'd0,
        SW_HELD  = 2'd1,
        SW_FLUSH = 2'd2
    } swap_state_t;

endpackage

// File: rtl/nbp_pair_swap.sv
// Reorders data bytes pairwise when swap is enabled: the first byte of a pair
// is held back, the second goes out first, then the held one follows.
// Assumes: pk_swap is stable for a whole message; pairs start at message start;
// commands and a lone last byte pass straight through.
module nbp_pair_swap
    import nbp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       swap_en,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_is_data,
    input  logic       in_last,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_is_data,
    output logic       out_last
);

    swap_state_t st;
    logic [7:0]  hold_data;
    logic        hold_last;
    logic        capture;

    // A data byte that opens a pair is held when swapping is on.
    assign capture = swap_en && in_is_data && !in_last;

    // Output mux and input ready per state.
    always_comb begin
        out_valid   = in_valid;
        out_data    = in_data;
        out_is_data = in_is_data;
        out_last    = in_last;
        in_ready    = out_ready;
        case (st)
            SW_PASS: begin
                if (capture) begin
                    out_valid = 1'b0;
                    in_ready  = 1'b1;
                end
            end
            SW_HELD: begin
                out_last = 1'b0;
            end
            SW_FLUSH: begin
                out_valid   = 1'b1;
                out_data    = hold_data;
                out_is_data = 1'b1;
                out_last    = hold_last;
                in_ready    = 1'b0;
            end
            default: begin
                out_valid = 1'b0;
                in_ready  = 1'b0;
            end
        endcase
    end

    // State and held byte update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SW_PASS;
            hold_data <= 8'h00;
            hold_last <= 1'b0;
        end else begin
            case (st)
                SW_PASS: if (in_valid && capture) begin
                    hold_data <= in_data;
                    st        <= SW_HELD;
                end
                SW_HELD: if (in_valid && out_ready) begin
                    hold_last <= in_last;
                    st        <= SW_FLUSH;
                end
                SW_FLUSH: if (out_ready) st <= SW_PASS;
                default: st <= SW_PASS;
            endcase
        end
    end

    AST_SWAP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SW_HELD && in_valid && out_ready) |=> (out_valid && out_is_data && !in_ready)); // R6

endmodule

// File: rtl/nbp_word_packer.sv
// Packs flagged 9-bit words into bytes. A 0..7 offset counter and a carry
// register holding the leftover low bits of the previous word do the job.
// A word at offset 7 leaves a full carry byte, which goes out as the ninth
// byte. Message tails are padded to nine bytes. A command is preceded by
// seven zero words. Bursts are closed every CHUNK_BYTES data bytes.
// Assumes: commands arrive on a frame boundary; input is held while not taken.
module nbp_word_packer
    import nbp_pkg::*;
#(
    parameter int CHUNK_BYTES = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_is_data,
    input  logic       in_last,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_last
);

    localparam int CW = $clog2(CHUNK_BYTES + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(CHUNK_BYTES - 1);

    pack_state_t st;
    logic [2:0]  k;
    logic [7:0]  creg;
    logic [CW-1:0] cnt;
    logic        frame_last;

    logic [8:0]  word;
    logic [8:0]  shifted;
    logic [15:0] wide;
    logic [7:0]  pack_byte;
    logic [7:0]  next_carry;
    logic        chunk_end;
    logic        data_fire;

    // Word assembly and bit alignment against the carry.
    always_comb begin
        word       = {in_is_data, in_data};
        shifted    = word >> ({1'b0, k} + 4'd1);
        pack_byte  = creg | shifted[7:0];
        wide       = {7'b0, word} << (4'd7 - {1'b0, k});
        next_carry = wide[7:0];
        chunk_end  = (cnt == CNT_TOP);
        data_fire  = (st == PK_RUN) && in_valid && in_is_data && out_ready;
    end

    // Output and ready per state.
    always_comb begin
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_last  = 1'b0;
        in_ready  = 1'b0;
        case (st)
            PK_RUN: begin
                if (in_valid && !in_is_data) begin
                    in_ready = !in_last;
                end else begin
                    out_valid = in_valid;
                    out_data  = pack_byte;
                    in_ready  = out_ready;
                end
            end
            PK_PAD: begin
                out_valid = 1'b1;
                out_data  = creg;
                out_last  = (k == 3'd7) && frame_last;
            end
            PK_NOPS: begin
                out_valid = 1'b1;
            end
            PK_CMD: begin
                out_valid = in_valid;
                out_data  = in_data;
                out_last  = 1'b1;
                in_ready  = out_ready;
            end
            PK_DROP: begin
                in_ready = 1'b1;
            end
            default: ;
        endcase
    end

    // Sequencing, offset, carry and burst counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= PK_RUN;
            k          <= 3'd0;
            creg       <= 8'h00;
            cnt        <= '0;
            frame_last <= 1'b0;
        end else begin
            case (st)
                PK_RUN: begin
                    if (in_valid && !in_is_data) begin
                        k  <= 3'd0;
                        st <= in_last ? PK_NOPS : PK_DROP;
                    end else if (data_fire) begin
                        creg       <= next_carry;
                        cnt        <= (in_last || chunk_end) ? '0 : cnt + 1'b1;
                        frame_last <= in_last || chunk_end;
                        if (k == 3'd7 || in_last) st <= PK_PAD;
                        else                      k  <= k + 3'd1;
                    end
                end
                PK_PAD: if (out_ready) begin
                    creg <= 8'h00;
                    if (k == 3'd7) begin
                        k  <= 3'd0;
                        st <= PK_RUN;
                    end else begin
                        k <= k + 3'd1;
                    end
                end
                PK_NOPS: if (out_ready) begin
                    if (k == 3'd7) begin
                        k  <= 3'd0;
                        st <= PK_CMD;
                    end else begin
                        k <= k + 3'd1;
                    end
                end
                PK_CMD: if (in_valid && out_ready) st <= PK_RUN;
                PK_DROP: if (in_valid && in_last) st <= PK_RUN;
                default: st <= PK_RUN;
            endcase
        end
    end

    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_is_data && !in_last) |=> !out_valid); // R4

    AST_NINTH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_fire && k == 3'd7) |=> (out_valid && !in_ready)); // R2

    AST_CMD_AFTER_NOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PK_NOPS && k == 3'd7 && out_ready) |=> (!out_valid || out_last)); // R3

endmodule

// File: rtl/nine_bit_packer.sv
// Top of the nine-bit packer: pair reorder stage followed by the word packer.
// The burst size is derived from the downstream buffer size.
// Assumes: input beats are held stable until accepted.
module nine_bit_packer #(
    parameter int OUT_BUF_BYTES = 36
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pk_swap,
    input  logic       pk_in_vld,
    output logic       pk_in_rdy,
    input  logic [7:0] pk_in_byte,
    input  logic       pk_in_is_data,
    input  logic       pk_in_end,
    output logic       pk_out_vld,
    input  logic       pk_out_rdy,
    output logic [7:0] pk_out_byte,
    output logic       pk_out_end
);

    localparam int RAW_CHUNK = (OUT_BUF_BYTES / 9) * 8;
    localparam int CHUNK     = (RAW_CHUNK < 8) ? 8 : RAW_CHUNK;

    logic       mid_valid;
    logic       mid_ready;
    logic [7:0] mid_data;
    logic       mid_is_data;
    logic       mid_last;

    nbp_pair_swap u_swap (
        .clk        (clk),
        .rst_n      (rst_n),
        .swap_en    (pk_swap),
        .in_valid   (pk_in_vld),
        .in_ready   (pk_in_rdy),
        .in_data    (pk_in_byte),
        .in_is_data (pk_in_is_data),
        .in_last    (pk_in_end),
        .out_valid  (mid_valid),
        .out_ready  (mid_ready),
        .out_data   (mid_data),
        .out_is_data(mid_is_data),
        .out_last   (mid_last)
    );

    nbp_word_packer #(.CHUNK_BYTES(CHUNK)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (mid_valid),
        .in_ready  (mid_ready),
        .in_data   (mid_data),
        .in_is_data(mid_is_data),
        .in_last   (mid_last),
        .out_valid (pk_out_vld),
        .out_ready (pk_out_rdy),
        .out_data  (pk_out_byte),
        .out_last  (pk_out_end)
    );

    // Output byte position within the current nine-byte frame (checking only).
    logic [3:0] fpos;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fpos <= 4'd0;
        end else if (pk_out_vld && pk_out_rdy) begin
            fpos <= (fpos == 4'd8) ? 4'd0 : fpos + 4'd1;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_out_vld && !pk_out_rdy) |=> (pk_out_vld && $stable(pk_out_byte) && $stable(pk_out_end))); // R8

    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_out_vld && pk_out_rdy && pk_out_end) |-> (fpos == 4'd8)); // R7

endmodule

// File: tb/nine_bit_packer_bench.sv
`timescale 1ns/1ps
module nine_bit_packer_bench;

    localparam int BUF   = 18;
    localparam int CHUNK = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pk_swap = 1'b0;
    logic       pk_in_vld = 1'b0;
    logic       pk_in_rdy;
    logic [7:0] pk_in_byte = 8'h00;
    logic       pk_in_is_data = 1'b1;
    logic       pk_in_end = 1'b0;
    logic       pk_out_vld;
    logic       pk_out_rdy = 1'b1;
    logic [7:0] pk_out_byte;
    logic       pk_out_end;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit stall_mode = 1'b0;

    logic [7:0] got_b[$];
    bit         got_l[$];
    logic [7:0] exp_b[$];
    bit         exp_l[$];
    logic [7:0] msg[64];

    always #2 clk = ~clk;

    nine_bit_packer #(.OUT_BUF_BYTES(BUF)) u_nine_bit_packer (
        .clk(clk), .rst_n(rst_n), .pk_swap(pk_swap),
        .pk_in_vld(pk_in_vld), .pk_in_rdy(pk_in_rdy), .pk_in_byte(pk_in_byte),
        .pk_in_is_data(pk_in_is_data), .pk_in_end(pk_in_end),
        .pk_out_vld(pk_out_vld), .pk_out_rdy(pk_out_rdy),
        .pk_out_byte(pk_out_byte), .pk_out_end(pk_out_end)
    );

    // Downstream ready pattern, changed away from the rising edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        pk_out_rdy <= stall_mode ? ((cyc % 3) != 0) : 1'b1;
    end

    // Output monitor, samples just before the rising edge.
    always begin
        @(negedge clk);
        #1;
        if (rst_n && pk_out_vld && pk_out_rdy) begin
            got_b.push_back(pk_out_byte);
            got_l.push_back(pk_out_end);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic send_beat(input logic [7:0] d, input bit is_data, input bit last);
        bit done;
        done = 1'b0;
        @(negedge clk);
        pk_in_vld     = 1'b1;
        pk_in_byte    = d;
        pk_in_is_data = is_data;
        pk_in_end     = last;
        while (!done) begin
            #1;
            if (pk_in_rdy) begin
                @(posedge clk);
                done = 1'b1;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    task automatic go_idle(input int cycles);
        @(negedge clk);
        pk_in_vld = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    // Expected frames of a data message, built from the packing rules.
    task automatic model_data(input int n, input bit sw);
        logic [7:0] a[64];
        for (int i = 0; i < n; i++) a[i] = msg[i];
        if (sw) begin
            for (int i = 0; i + 1 < n; i += 2) begin
                a[i]     = msg[i + 1];
                a[i + 1] = msg[i];
            end
        end
        for (int c = 0; c < n; c += CHUNK) begin
            int cl;
            cl = (n - c < CHUNK) ? n - c : CHUNK;
            for (int g = 0; g < cl; g += 8) begin
                logic [71:0] fr;
                int m;
                m  = (cl - g < 8) ? cl - g : 8;
                fr = '0;
                for (int j = 0; j < m; j++) fr[71 - 9*j -: 9] = {1'b1, a[c + g + j]};
                for (int t = 0; t < 9; t++) begin
                    exp_b.push_back(fr[71 - 8*t -: 8]);
                    exp_l.push_back((t == 8) && (g + 8 >= cl));
                end
            end
        end
    endtask

    task automatic compare(input string req);
        check(got_b.size() == exp_b.size(), req, "byte count", got_b.size(), exp_b.size());
        if (got_b.size() == exp_b.size()) begin
            for (int i = 0; i < exp_b.size(); i++) begin
                check(got_b[i] == exp_b[i], req, $sformatf("byte %0d", i), got_b[i], exp_b[i]);
                check(got_l[i] == exp_l[i], req, $sformatf("end %0d", i), got_l[i], exp_l[i]);
            end
        end
        got_b.delete(); got_l.delete(); exp_b.delete(); exp_l.delete();
    endtask

    task automatic run_data(input int n, input bit sw, input string req);
        for (int i = 0; i < n; i++) msg[i] = 8'((i * 37) + (n * 11) + 5);
        @(negedge clk);
        pk_swap = sw;
        for (int i = 0; i < n; i++) send_beat(msg[i], 1'b1, i == n - 1);
        go_idle(60);
        model_data(n, sw);
        compare(req);
    endtask

    task automatic run_cmd(input logic [7:0] c);
        send_beat(c, 1'b0, 1'b1);
        go_idle(40);
        for (int t = 0; t < 8; t++) begin
            exp_b.push_back(8'h00);
            exp_l.push_back(1'b0);
        end
        exp_b.push_back(c);
        exp_l.push_back(1'b1);
        compare("R3");
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        check(pk_out_vld == 1'b0, "R1", "out valid after reset", pk_out_vld, 0);
        check(pk_in_rdy == 1'b1, "R1", "in ready after reset", pk_in_rdy, 1);

        // R2 explicit first group
        for (int i = 0; i < 8; i++) msg[i] = 8'hA0 + 8'(i * 3);
        for (int i = 0; i < 8; i++) send_beat(msg[i], 1'b1, i == 7);
        go_idle(30);
        check(got_b.size() == 9, "R2", "group size", got_b.size(), 9);
        if (got_b.size() == 9) begin
            check(got_b[0] == {1'b1, msg[0][7:1]}, "R2", "first byte", got_b[0], {1'b1, msg[0][7:1]});
            check(got_b[8] == msg[7], "R2", "ninth byte", got_b[8], msg[7]);
        end
        got_b.delete(); got_l.delete();

        for (int ph = 0; ph < 2; ph++) begin
            stall_mode = (ph == 1);
            for (int n = 1; n <= 40; n++) begin
                for (int s = 0; s < 2; s++) begin
                    string req;
                    if (s == 1)          req = "R6";
                    else if (n > CHUNK)  req = "R7";
                    else if (n % 8 == 0) req = "R2";
                    else                 req = "R5";
                    if (ph == 1) req = {req, "/R8"};
                    run_data(n, s[0], req);
                end
                if (n % 8 == 3) run_cmd(8'(n * 29 + 1));
            end
            // R4 illegal command, then normal traffic must follow
            send_beat(8'h2C, 1'b0, 1'b0);
            send_beat(8'h11, 1'b0, 1'b0);
            send_beat(8'h3A, 1'b1, 1'b1);
            go_idle(30);
            check(got_b.size() == 0, "R4", "bytes after illegal command", got_b.size(), 0);
            got_b.delete(); got_l.delete();
            run_cmd(8'h29);
            run_data(5, 1'b0, "R4");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule